// File: doc/BRIEF.md
# Multiplier-free I/Q frequency shifter

This block shifts a stream of paired in-phase (I) and quadrature (Q) signed samples in frequency by one half or one quarter of its own input sample rate. No multipliers are used. At these two shift frequencies every carrier value is 0, +1 or −1, so each output channel is one of three things: zero, one of the two input channels, or the negation of one of them. Negation saturates, so the most negative code becomes the most positive code. The output streams run at the same rate as the input and appear one clock after each accepted sample.

A 2-bit frequency code selects the shift:
- 00 bypasses the block.
- 01 shifts by half the rate.
- 10 and 11 both shift by a quarter of the rate.

A real/complex select chooses how the quarter-rate shift is done. With the select at 1, the shift is real: each channel is multiplied by the cosine sequence. With the select at 0, the shift is complex and rejects one image. A direction bit then sets the sign of the rotation, and that sets which sideband is cancelled. A complex request with code 00 or 01 has no effect, and those codes keep their real behaviour.

Control is built around a four-state phase machine with the states PH0, PH1, PH2 and PH3. It has three transitions:
- STEP: on an accepted sample, move from PHk to PH(k+1 mod 4).
- HOLD: with no sample, stay in the current state.
- RESTART: when the decoded mixing mode changes, treat the current cycle as PH0. A sample in that cycle uses PH0 and then steps to PH1.

The decoded mixing modes are PASS, HALF, QREAL, QCPOS and QCNEG. Codes 10 and 11 decode to the same mode, so switching between them is not a change. Reset puts the machine in PH0 with the mode set to PASS.

Top module: `iq_mixer`

## Requirements
- R1: While rst_n is low, out_valid, out_i and out_q are all 0 at the next clock edge.
- R2: A sample accepted with in_valid=1 at a clock edge appears on out_i/out_q with out_valid=1 right after that edge. If in_valid=0 at an edge, out_valid is 0 after it and out_i/out_q keep their previous values.
- R3: Code 00 passes I and Q through unchanged, whatever real_sel and sign_sel are.
- R4: Code 01 multiplies both channels by the sequence +1, −1 over successive accepted samples. real_sel=0 has no effect with this code.
- R5: Codes 10 and 11 with real_sel=1 multiply both channels by +1, 0, −1, 0 over successive accepted samples. Changing between 10 and 11 does not restart the sequence.
- R6: Codes 10/11 with real_sel=0 and sign_sel=1 produce (I,Q), (−Q,I), (−I,−Q), (Q,−I) over phases 0 to 3. This is I·cos−Q·sin and I·sin+Q·cos, where the sine sequence is 0, +1, 0, −1.
- R7: Codes 10/11 with real_sel=0 and sign_sel=0 produce (I,Q), (Q,−I), (−I,−Q), (−Q,I) over phases 0 to 3, which is the same rotation with the sine terms negated.
- R8: Negating −2^(W−1) gives 2^(W−1)−1. No output takes the value −2^(W−1) unless an input had that value.
- R9: The phase is 0 after reset and restarts at 0 when the decoded mode changes. It advances only on accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair valid |
| in_i | input | W | In-phase input sample, two's complement |
| in_q | input | W | Quadrature input sample, two's complement |
| mode_code | input | 2 | 00 bypass, 01 half-rate, 10/11 quarter-rate |
| real_sel | input | 1 | 1 real mixing, 0 complex image-reject (quarter rate only) |
| sign_sel | input | 1 | Complex rotation sign: 0 negative, 1 positive |
| out_valid | output | 1 | Output pair valid |
| out_i | output | W | In-phase output |
| out_q | output | W | Quadrature output |

## Verification
Every result is due one clock after the edge that accepts its sample, because the output registers are the only stage. The bench therefore drives each sample on a falling edge and compares out_valid, out_i and out_q 1 ns after the next rising edge. Mode changes are applied during a cycle with in_valid low. The bench then resets its own phase count whenever the decoded mode it computes changes, and it checks that idle cycles neither advance the phase nor disturb the held outputs.

// File: rtl/iq_mixer_pkg.sv
package iq_mixer_pkg;

    typedef enum logic [2:0] {
        MIX_PASS,
        MIX_HALF,
        MIX_QREAL,
        MIX_QCPOS,
        MIX_QCNEG
    } mix_mode_t;

    typedef enum logic [1:0] {
        PH0,
        PH1,
        PH2,
        PH3
    } phase_t;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_I,
        SRC_Q
    } src_t;

    typedef struct packed {
        src_t src;
        logic neg;
    } route_t;

endpackage

// File: rtl/iq_mode_decode.sv
module iq_mode_decode
    import iq_mixer_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic       real_sel,
    input  logic       sign_sel,
    output mix_mode_t  mode
);

    always_comb begin
        unique case (mode_code)
            2'b00:   mode = MIX_PASS;
            2'b01:   mode = MIX_HALF;
            default: begin
                if (real_sel)
                    mode = MIX_QREAL;
                else if (sign_sel)
                    mode = MIX_QCPOS;
                else
                    mode = MIX_QCNEG;
            end
        endcase
    end

endmodule

// File: rtl/iq_phase_fsm.sv
module iq_phase_fsm
    import iq_mixer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mix_mode_t mode,
    input  logic      adv,
    output phase_t    phase_cur
);

    phase_t    state_q;
    phase_t    state_d;
    mix_mode_t mode_q;
    logic      restart;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH0;
            mode_q  <= MIX_PASS;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    // Outputs and transitions: RESTART, STEP, HOLD
    always_comb begin
        restart   = (mode != mode_q);
        phase_cur = restart ? PH0 : state_q;
        if (adv) begin
            unique case (phase_cur)
                PH0: state_d = PH1;
                PH1: state_d = PH2;
                PH2: state_d = PH3;
                PH3: state_d = PH0;
            endcase
        end else begin
            state_d = phase_cur;
        end
    end

endmodule

// File: rtl/iq_sat_neg.sv
module iq_sat_neg #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] din,
    input  logic                neg,
    output logic signed [W-1:0] dout
);

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (!neg)
            dout = din;
        else if (din == MIN_V)
            dout = MAX_V;
        else
            dout = -din;
    end

endmodule

// File: rtl/iq_mixer.sv
module iq_mixer
    import iq_mixer_pkg::*;
#(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic [1:0]          mode_code,
    input  logic                real_sel,
    input  logic                sign_sel,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);

    localparam int NCH = 2;

    mix_mode_t          mode;
    phase_t             phase;
    route_t             rt      [NCH];
    logic signed [W-1:0] src_val [NCH];
    logic signed [W-1:0] mix_val [NCH];

    iq_mode_decode u_dec (
        .mode_code (mode_code),
        .real_sel  (real_sel),
        .sign_sel  (sign_sel),
        .mode      (mode)
    );

    iq_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .adv       (in_valid),
        .phase_cur (phase)
    );

    // Channel routing per mode and phase: index 0 feeds I out, 1 feeds Q out
    always_comb begin
        rt[0] = '{src: SRC_I, neg: 1'b0};
        rt[1] = '{src: SRC_Q, neg: 1'b0};
        unique case (mode)
            MIX_PASS: ;
            MIX_HALF: begin
                rt[0].neg = phase[0];
                rt[1].neg = phase[0];
            end
            MIX_QREAL: begin
                unique case (phase)
                    PH0: ;
                    PH2: begin
                        rt[0].neg = 1'b1;
                        rt[1].neg = 1'b1;
                    end
                    PH1, PH3: begin
                        rt[0].src = SRC_ZERO;
                        rt[1].src = SRC_ZERO;
                    end
                endcase
            end
            MIX_QCPOS: begin
                unique case (phase)
                    PH0: ;
                    PH1: begin
                        rt[0] = '{src: SRC_Q, neg: 1'b1};
                        rt[1] = '{src: SRC_I, neg: 1'b0};
                    end
                    PH2: begin
                        rt[0].neg = 1'b1;
                        rt[1].neg = 1'b1;
                    end
                    PH3: begin
                        rt[0] = '{src: SRC_Q, neg: 1'b0};
                        rt[1] = '{src: SRC_I, neg: 1'b1};
                    end
                endcase
            end
            MIX_QCNEG: begin
                unique case (phase)
                    PH0: ;
                    PH1: begin
                        rt[0] = '{src: SRC_Q, neg: 1'b0};
                        rt[1] = '{src: SRC_I, neg: 1'b1};
                    end
                    PH2: begin
                        rt[0].neg = 1'b1;
                        rt[1].neg = 1'b1;
                    end
                    PH3: begin
                        rt[0] = '{src: SRC_Q, neg: 1'b1};
                        rt[1] = '{src: SRC_I, neg: 1'b0};
                    end
                endcase
            end
            default: ;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            unique case (rt[ch].src)
                SRC_I:   src_val[ch] = in_i;
                SRC_Q:   src_val[ch] = in_q;
                default: src_val[ch] = '0;
            endcase
        end

        iq_sat_neg #(.W(W)) u_neg (
            .din  (src_val[ch]),
            .neg  (rt[ch].neg),
            .dout (mix_val[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= mix_val[0];
                out_q <= mix_val[1];
            end
        end
    end

endmodule

// File: rtl/iq_mixer_chk.sv
module iq_mixer_chk #(
    parameter int W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_i,
    input logic signed [W-1:0] in_q,
    input logic [1:0]          mode_code,
    input logic                real_sel,
    input logic                sign_sel,
    input logic                out_valid,
    input logic signed [W-1:0] out_i,
    input logic signed [W-1:0] out_q
);

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));

    // R2: an idle cycle drops valid and holds the data
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

    // R3: bypass code returns the inputs unchanged
    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_code == 2'b00)
        |=> (out_i == $past(in_i) && out_q == $past(in_q)));

    // R5: real modes apply one carrier to both channels
    assert_real_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i == in_q && (real_sel || !mode_code[1]))
        |=> (out_i == out_q));

    // R6: complex modes only permute and negate
    assert_cplx_mag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_code[1] && !real_sel && in_i == in_q && in_i != MIN_V)
        |=> ((out_i == $past(in_i) || out_i == -$past(in_i)) &&
             (out_q == $past(in_i) || out_q == -$past(in_i))));

    // R8: negation never wraps into the most negative code
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i != MIN_V && in_q != MIN_V)
        |=> (out_i != MIN_V && out_q != MIN_V));

endmodule

bind iq_mixer iq_mixer_chk #(.W(W)) u_chk (.*);

// File: tb/iq_mixer_test.sv
`timescale 1ns/1ps
module iq_mixer_test;

    localparam int W = 14;
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0;
    logic signed [W-1:0] in_q = '0;
    logic [1:0]          mode_code = 2'b00;
    logic                real_sel = 1'b1;
    logic                sign_sel = 1'b0;
    logic                out_valid;
    logic signed [W-1:0] out_i;
    logic signed [W-1:0] out_q;

    int n_cmp = 0;
    int n_bad = 0;
    int ph = 0;
    int cur_eff = 0;
    logic signed [W-1:0] last_i = '0;
    logic signed [W-1:0] last_q = '0;

    iq_mixer #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .mode_code(mode_code), .real_sel(real_sel), .sign_sel(sign_sel),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic signed [W-1:0] nsat(input logic signed [W-1:0] x);
        return (x == MINV) ? MAXV : -x;
    endfunction

    // 0 pass, 1 half, 2 quarter real, 3 complex +, 4 complex -
    function automatic int eff(input logic [1:0] c, input logic r, input logic s);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        if (r) return 2;
        return s ? 3 : 4;
    endfunction

    task automatic set_mode(input logic [1:0] c, input logic r, input logic s);
        int e;
        @(negedge clk);
        in_valid  = 1'b0;
        mode_code = c;
        real_sel  = r;
        sign_sel  = s;
        e = eff(c, r, s);
        if (e != cur_eff) ph = 0;
        cur_eff = e;
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                        input string tag);
        logic signed [W-1:0] ei, eq;
        ei = a; eq = b;
        case (cur_eff)
            1: if (ph % 2 == 1) begin ei = nsat(a); eq = nsat(b); end
            2: case (ph)
                   1, 3: begin ei = '0; eq = '0; end
                   2: begin ei = nsat(a); eq = nsat(b); end
                   default: ;
               endcase
            3: case (ph)
                   1: begin ei = nsat(b); eq = a; end
                   2: begin ei = nsat(a); eq = nsat(b); end
                   3: begin ei = b; eq = nsat(a); end
                   default: ;
               endcase
            4: case (ph)
                   1: begin ei = b; eq = nsat(a); end
                   2: begin ei = nsat(a); eq = nsat(b); end
                   3: begin ei = nsat(b); eq = a; end
                   default: ;
               endcase
            default: ;
        endcase
        @(negedge clk);
        in_valid = 1'b1;
        in_i = a;
        in_q = b;
        @(posedge clk);
        #1;
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " out_i"}, int'(out_i), int'(ei));
        check({tag, " out_q"}, int'(out_q), int'(eq));
        last_i = ei;
        last_q = eq;
        ph = (ph + 1) % 4;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_i = 14'sd1111;
        in_q = -14'sd2222;
        @(posedge clk);
        #1;
        check({tag, " valid low"}, int'(out_valid), 0);
        check({tag, " hold i"}, int'(out_i), int'(last_i));
        check({tag, " hold q"}, int'(out_q), int'(last_q));
    endtask

    task automatic t_reset();
        in_valid = 1'b1; in_i = 14'sd500; in_q = 14'sd600;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset i", int'(out_i), 0);
        check("R1 reset q", int'(out_q), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        ph = 0; cur_eff = 0;
    endtask

    task automatic t_pass();
        set_mode(2'b00, 1'b1, 1'b0);
        send(14'sd100, -14'sd200, "R3 pass");
        send(MINV, MAXV, "R3 pass extremes");
        set_mode(2'b00, 1'b0, 1'b1);
        send(14'sd7, 14'sd9, "R3 pass complex ignored");
        send(-14'sd7, 14'sd3, "R3 pass complex ignored");
    endtask

    task automatic t_half();
        set_mode(2'b01, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) send(14'sd300 + 14'(k), -14'sd50, "R4 half");
        set_mode(2'b01, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) send(14'sd40, 14'sd41 + 14'(k), "R4 half complex ignored");
    endtask

    task automatic t_qreal();
        set_mode(2'b10, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) send(14'sd1000, 14'sd2000, "R5 qreal code10");
        set_mode(2'b11, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) send(14'sd1000 - 14'(k), -14'sd33, "R5 qreal code11 continues");
    endtask

    task automatic t_cplx();
        set_mode(2'b10, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) send(14'sd123, -14'sd456, "R6 complex plus");
        set_mode(2'b11, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) send(14'sd123, -14'sd456, "R7 complex minus");
    endtask

    task automatic t_sat();
        set_mode(2'b01, 1'b1, 1'b0);
        send(MINV, MINV, "R8 half even");
        send(MINV, MINV, "R8 half odd saturates");
        set_mode(2'b10, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) send(MINV, MAXV, "R8 complex saturates");
    endtask

    task automatic t_phase();
        set_mode(2'b10, 1'b1, 1'b0);
        send(14'sd77, 14'sd88, "R9 step");
        idle("R2 gap");
        idle("R2 gap");
        send(14'sd77, 14'sd88, "R9 phase held over gap");
        send(14'sd77, 14'sd88, "R9 phase held over gap");
        set_mode(2'b11, 1'b0, 1'b0);
        send(14'sd5, 14'sd6, "R9 restart on mode change");
        send(14'sd5, 14'sd6, "R9 after restart");
        idle("R2 gap after complex");
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pass();
        t_half();
        t_qreal();
        t_cplx();
        t_sat();
        t_phase();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule